// File: doc/BRIEF.md
# 100 Mb/s Receive Carrier Sense and Data-Valid Generator

This block sits between the code-group aligner of a 100 Mb/s physical layer and the media access controller. Every clock cycle it receives one aligned 5-bit code group. From that stream it drives three indications toward the MAC:

- carrier sense (`crs`)
- receive data valid (`rx_dv`)
- receive error (`rx_er`)

Any code group other than idle raises carrier sense. Data valid follows only once a proper start delimiter pair has been seen. Reception ends on an end delimiter pair, or on two idle code groups in a row. Activity that does not open with a correct start delimiter is reported as a false carrier on `rx_er`.

A duplex input sets how `crs` relates to the transmitter. In half duplex, carrier sense also covers the cycles in which the local transmitter is enabled. In full duplex, it reports reception only. Code-group alignment, descrambling and nibble decoding are done elsewhere.

Top module: `rx_carrier_sense`

## Requirements
- R1: While and right after a synchronous active-high reset, with `tx_en` low, `crs`, `rx_dv` and `rx_er` are all low.
- R2: When idle, the first code group that is not IDLE (5'b11111) raises `crs` in the cycle after it is sampled.
- R3: A /J/ (5'b11000) followed directly by a /K/ (5'b10001) raises `rx_dv` in the cycle after /K/ is sampled. After /J/ alone, `rx_dv` stays low.
- R4: During data, a /T/ (5'b01101) followed directly by an /R/ (5'b00111) drops the receive part of `crs` and drops `rx_dv` in the cycle after /R/ is sampled. An /R/ that does not follow /T/ has no effect.
- R5: During data, two consecutive IDLE code groups end reception in the cycle after the second one. A single IDLE between data groups does not.
- R6: If the first non-idle group is not /J/, or /J/ is not followed by /K/, `rx_er` rises instead of `rx_dv`, with `crs` high. A later /J/ /K/ pair does not start data while the false carrier lasts.
- R7: A false carrier clears only after two consecutive IDLE code groups. It clears in the cycle after the second one.
- R8: With `full_duplex` low, `tx_en` high forces `crs` high in the same cycle. With `full_duplex` high, `tx_en` has no effect on `crs`.
- R9: `rx_dv` and `rx_er` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock, one group per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rx_code | input | 5 | Aligned receive code group |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_en | input | 1 | Local transmitter enabled |
| crs | output | 1 | Carrier sense toward the MAC |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error (false carrier) |

## Verification
Each receive indication is decoded straight from the registered state. A wrong state therefore shows at the ports one cycle after the code group that caused it:

- A missed start pair keeps `rx_dv` low.
- A false carrier wrongly taken as data shows as `rx_dv` where `rx_er` was expected.
- A stuck state keeps `crs` high past the second idle.

The sequences are chosen to reach every state edge: single idles and lone /R/ groups inside data and inside a false carrier, and a start pair arriving during a false carrier. With these, an exit rule that fires too early or too late differs from the expected value within one code group.

// File: rtl/rx_cs_pkg.sv
package rx_cs_pkg;

    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
    localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
    localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
    localparam logic [CODE_W-1:0] CG_R    = 5'b00111;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CARRIER = 2'd1,
        ST_DATA    = 2'd2,
        ST_FALSE   = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic is_idle;
        logic is_j;
        logic is_k;
        logic end_pair;
        logic idle_pair;
    } pair_flags_t;

    typedef struct packed {
        logic crs;
        logic dv;
        logic er;
    } mac_ind_t;

    function automatic logic code_eq(input logic [CODE_W-1:0] a,
                                     input logic [CODE_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/rcs_pair_track.sv
module rcs_pair_track
    import rx_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output pair_flags_t       flags
);
    logic [CODE_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= CG_IDLE;
        else     prev_q <= code;
    end

    always_comb begin
        flags.is_idle   = code_eq(code, CG_IDLE);
        flags.is_j      = code_eq(code, CG_J);
        flags.is_k      = code_eq(code, CG_K);
        flags.end_pair  = code_eq(prev_q, CG_T) && code_eq(code, CG_R);
        flags.idle_pair = code_eq(prev_q, CG_IDLE) && code_eq(code, CG_IDLE);
    end
endmodule

// File: rtl/rcs_state_fsm.sv
module rcs_state_fsm
    import rx_cs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pair_flags_t flags,
    output rx_state_t   state
);
    rx_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!flags.is_idle) nxt = flags.is_j ? ST_CARRIER : ST_FALSE;
            end
            ST_CARRIER: begin
                nxt = flags.is_k ? ST_DATA : ST_FALSE;
            end
            ST_DATA: begin
                if (flags.end_pair || flags.idle_pair) nxt = ST_IDLE;
            end
            ST_FALSE: begin
                if (flags.idle_pair) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/rcs_ind_map.sv
module rcs_ind_map
    import rx_cs_pkg::*;
(
    input  rx_state_t state,
    input  logic      full_duplex,
    input  logic      tx_en,
    output mac_ind_t  ind
);
    logic rx_active;
    logic tx_cover;

    always_comb begin
        rx_active = (state != ST_IDLE);
        tx_cover  = !full_duplex && tx_en;
        ind.crs   = rx_active || tx_cover;
        ind.dv    = (state == ST_DATA);
        ind.er    = (state == ST_FALSE);
    end
endmodule

// File: rtl/rx_carrier_sense.sv
module rx_carrier_sense
    import rx_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] rx_code,
    input  logic              full_duplex,
    input  logic              tx_en,
    output logic              crs,
    output logic              rx_dv,
    output logic              rx_er
);
    pair_flags_t flags;
    rx_state_t   state;
    mac_ind_t    ind;

    rcs_pair_track u_pair (
        .clk   (clk),
        .rst   (rst),
        .code  (rx_code),
        .flags (flags)
    );

    rcs_state_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .state (state)
    );

    rcs_ind_map u_map (
        .state       (state),
        .full_duplex (full_duplex),
        .tx_en       (tx_en),
        .ind         (ind)
    );

    assign crs   = ind.crs;
    assign rx_dv = ind.dv;
    assign rx_er = ind.er;
endmodule

// File: rtl/rx_carrier_sense_chk.sv
module rx_carrier_sense_chk
    import rx_cs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] rx_code,
    input logic              full_duplex,
    input logic              tx_en,
    input logic              crs,
    input logic              rx_dv,
    input logic              rx_er
);
    AST_DV_ER_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rx_dv && rx_er)); // R9

    AST_DV_AFTER_JK: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dv) |-> ($past(rx_code) == CG_K && $past(rx_code, 2) == CG_J)); // R3

    AST_DV_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(rx_dv) && !$past(rst)) |->
        (($past(rx_code) == CG_R && $past(rx_code, 2) == CG_T) ||
         ($past(rx_code) == CG_IDLE && $past(rx_code, 2) == CG_IDLE))); // R4

    AST_ER_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(rx_er) && !$past(rst)) |->
        ($past(rx_code) == CG_IDLE && $past(rx_code, 2) == CG_IDLE)); // R7

    AST_IND_CRS: assert property (@(posedge clk) disable iff (rst)
        (rx_dv || rx_er) |-> crs); // R6

    AST_HALF_TX_CRS: assert property (@(posedge clk) disable iff (rst)
        (!full_duplex && tx_en) |-> crs); // R8

    AST_IDLE_GAP_NO_DV: assert property (@(posedge clk) disable iff (rst)
        (!rx_dv && $past(rx_code) == CG_IDLE && !$past(rst)) |=> !rx_dv); // R3
endmodule

bind rx_carrier_sense rx_carrier_sense_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_code     (rx_code),
    .full_duplex (full_duplex),
    .tx_en       (tx_en),
    .crs         (crs),
    .rx_dv       (rx_dv),
    .rx_er       (rx_er)
);

// File: tb/rx_carrier_sense_bench.sv
module rx_carrier_sense_bench;
    import rx_cs_pkg::*;

    localparam logic [4:0] CG_D = 5'b01010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rx_code = CG_IDLE;
    logic       full_duplex = 1'b1;
    logic       tx_en = 1'b0;
    logic       crs, rx_dv, rx_er;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  crs;
        logic  dv;
        logic  er;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    rx_carrier_sense u_rx_carrier_sense (
        .clk         (clk),
        .rst         (rst),
        .rx_code     (rx_code),
        .full_duplex (full_duplex),
        .tx_en       (tx_en),
        .crs         (crs),
        .rx_dv       (rx_dv),
        .rx_er       (rx_er)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (crs !== e.crs || rx_dv !== e.dv || rx_er !== e.er) begin
            errors++;
            $display("FAIL %s: got crs=%b dv=%b er=%b expected crs=%b dv=%b er=%b",
                     e.tag, crs, rx_dv, rx_er, e.crs, e.dv, e.er);
        end
        checks++;
        if (rx_dv === 1'b1 && rx_er === 1'b1) begin
            errors++;
            $display("FAIL R9: got dv=1 er=1 expected not both");
        end
    endtask

    task automatic send(input logic [4:0] c, input logic ec, input logic ed,
                        input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        rx_code = c;
        e.crs = ec; e.dv = ed; e.er = ee; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        exp_t e;
        repeat (3) @(negedge clk);
        e.crs = 1'b0; e.dv = 1'b0; e.er = 1'b0; e.tag = "R1 in reset";
        compare(e);
        @(negedge clk);
        rst = 1'b0;
        e.tag = "R1 after reset";
        exp_q.push_back(e);

        // normal frame with lone R inside data
        send(CG_IDLE, 0, 0, 0, "R2 idle keeps crs low");
        send(CG_J,    1, 0, 0, "R2 crs on first activity, R3 no dv on J only");
        send(CG_K,    1, 1, 0, "R3 dv after J K");
        send(CG_D,    1, 1, 0, "R3 data");
        send(CG_R,    1, 1, 0, "R4 lone R ignored");
        send(CG_D,    1, 1, 0, "R4 data after lone R");
        send(CG_T,    1, 1, 0, "R4 T alone keeps dv");
        send(CG_R,    0, 0, 0, "R4 end on T R");
        send(CG_IDLE, 0, 0, 0, "R4 idle after end");

        // end by two idles, single idle ignored
        send(CG_J,    1, 0, 0, "R2 second frame");
        send(CG_K,    1, 1, 0, "R3 second frame");
        send(CG_D,    1, 1, 0, "R5 data");
        send(CG_IDLE, 1, 1, 0, "R5 single idle");
        send(CG_D,    1, 1, 0, "R5 data after single idle");
        send(CG_IDLE, 1, 1, 0, "R5 first idle");
        send(CG_IDLE, 0, 0, 0, "R5 end on two idles");

        // false carrier: first group not J, J K inside
        send(CG_D,    1, 0, 1, "R6 false carrier non-J");
        send(CG_J,    1, 0, 1, "R6 J during false carrier");
        send(CG_K,    1, 0, 1, "R6 K during false carrier");
        send(CG_IDLE, 1, 0, 1, "R7 single idle keeps er");
        send(CG_D,    1, 0, 1, "R7 activity again");
        send(CG_IDLE, 1, 0, 1, "R7 first idle");
        send(CG_IDLE, 0, 0, 0, "R7 clear on two idles");

        // false carrier: J not followed by K
        send(CG_J,    1, 0, 0, "R3 J waits");
        send(CG_D,    1, 0, 1, "R6 J without K");
        send(CG_IDLE, 1, 0, 1, "R7 first idle");
        send(CG_IDLE, 0, 0, 0, "R7 clear");

        // duplex handling
        @(negedge clk); full_duplex = 1'b0; tx_en = 1'b1;
        exp_q.push_back('{1'b1, 1'b0, 1'b0, "R8 half duplex tx covers crs"});
        send(CG_IDLE, 1, 0, 0, "R8 half duplex tx idle rx");
        @(negedge clk); full_duplex = 1'b1;
        exp_q.push_back('{1'b0, 1'b0, 1'b0, "R8 full duplex tx ignored"});
        send(CG_J,    1, 0, 0, "R8 full duplex rx carrier");
        send(CG_K,    1, 1, 0, "R8 full duplex rx data");
        @(negedge clk); tx_en = 1'b0; rx_code = CG_T;
        exp_q.push_back('{1'b1, 1'b1, 1'b0, "R8 rx crs without tx"});
        send(CG_R,    0, 0, 0, "R4 end during duplex test");

        // reset during data
        send(CG_J,    1, 0, 0, "R2 before reset");
        send(CG_K,    1, 1, 0, "R3 before reset");
        @(negedge clk); rst = 1'b1; rx_code = CG_D;
        exp_q.push_back('{1'b0, 1'b0, 1'b0, "R1 reset clears data"});
        @(negedge clk); rst = 1'b0; rx_code = CG_IDLE;
        exp_q.push_back('{1'b0, 1'b0, 1'b0, "R1 idle after reset"});

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule